// File: doc/BRIEF.md
# Indexed MSI Message Store

This block keeps a small table of message-signalled interrupt entries on the device side and turns per-vector interrupt requests into memory-write messages. Each entry holds a 64-bit target address, a 32-bit payload and a mask bit. Software does not see the table as a flat memory. It writes a vector number into a select register, and then reads or writes the chosen entry through a fixed set of address, payload and mask registers.

While the store is enabled, a request on a vector sets that vector's pending bit. Any pending vector that is unmasked is issued as one message on a valid/ready output, lowest index first. The pending bit is cleared when the consumer accepts the message. A request on a masked vector stays pending until software unmasks that vector. While the store is disabled, requests bypass the table and appear on a separate fallback output in the same cycle.

Top module: `msi_vector_store`

## Requirements
- R1: After reset, the enable bit reads 0, the select register reads 0, every entry's mask reads 1 and `msg_valid` is low.
- R2: Word 0 bits [31:16] always read the parameter `NUM_VEC`, and writes to those bits have no effect. Word 0 bit 0 is the enable bit and is read/write. The other bits of word 0 read 0.
- R3: Word 1 bits [15:0] hold the vector select. A write of a value greater than or equal to `NUM_VEC` is ignored and the previous selection is kept.
- R4: The selected entry is read and written through four words: word 2 holds address bits [31:0], word 3 holds address bits [63:32], word 4 holds the payload, and word 5 bit 0 holds the mask (1 = masked). A write changes only the entry that is selected. Words 6 and 7, and all unused bits, read 0.
- R5: While enable is 0, `fb_irq` equals `irq_req` in the same cycle, and no message is issued for those requests.
- R6: While enabled, a request on a masked vector produces no message. Once the vector is unmasked, exactly one message carrying that entry's address and payload is issued.
- R7: When several unmasked vectors are pending, their messages are issued in ascending vector order, one per accepted handshake.
- R8: While `msg_valid` is high and `msg_ready` is low, `msg_valid`, `msg_addr` and `msg_data` hold steady. This is true even if software rewrites the entry. The pending bit is cleared only on the handshake, so each request yields exactly one message.
- R9: While enabled, a request on an unmasked vector issues one message with that entry's `{word 3, word 2}` as the address and word 4 as the payload, and `fb_irq` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register word index |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Read data for `reg_addr`, combinational |
| irq_req | input | NUM_VEC | Per-vector interrupt request, one event per cycle high |
| fb_irq | output | NUM_VEC | Requests forwarded to the fallback path while disabled |
| msg_valid | output | 1 | Message available |
| msg_ready | input | 1 | Consumer accepts the message |
| msg_addr | output | 64 | Message target address |
| msg_data | output | 32 | Message payload |

## Verification
The bench builds the block with `NUM_VEC = 8`. With this value the select bound is three bits wide, so the out-of-range values 8 and 0xFFFF can be tested. It also gives room to raise three vectors together with distinct, non-adjacent indices, which exercises the ascending service order. Backpressure is held for several cycles while the in-flight entry is rewritten, which shows that the message is latched and not read live from the table.

// File: rtl/msi_vector_store.sv
module msi_vector_store #(
  parameter int NUM_VEC = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               reg_we,
  input  logic [2:0]         reg_addr,
  input  logic [31:0]        reg_wdata,
  output logic [31:0]        reg_rdata,
  input  logic [NUM_VEC-1:0] irq_req,
  output logic [NUM_VEC-1:0] fb_irq,
  output logic               msg_valid,
  input  logic               msg_ready,
  output logic [63:0]        msg_addr,
  output logic [31:0]        msg_data
);
  localparam int SEL_W = (NUM_VEC > 1) ? $clog2(NUM_VEC) : 1;
  localparam logic [15:0] COUNT = 16'(NUM_VEC);

  logic               en_q;
  logic [SEL_W-1:0]   sel_q;
  logic [31:0]        lo_q  [NUM_VEC];
  logic [31:0]        hi_q  [NUM_VEC];
  logic [31:0]        dat_q [NUM_VEC];
  logic [NUM_VEC-1:0] mask_q;
  logic [NUM_VEC-1:0] pend_q;
  logic [SEL_W-1:0]   cur_vec;
  logic               found;
  logic [SEL_W-1:0]   pick;
  logic [NUM_VEC-1:0] clr;

  wire wr_en   = reg_we && reg_addr == 3'd0;
  wire wr_sel  = reg_we && reg_addr == 3'd1;
  wire wr_lo   = reg_we && reg_addr == 3'd2;
  wire wr_hi   = reg_we && reg_addr == 3'd3;
  wire wr_dat  = reg_we && reg_addr == 3'd4;
  wire wr_mask = reg_we && reg_addr == 3'd5;
  wire hs      = msg_valid && msg_ready;
  wire [NUM_VEC-1:0] live = pend_q & ~mask_q;

  assign fb_irq = irq_req & {NUM_VEC{~en_q}};

  always_comb begin
    found = 1'b0;
    pick  = '0;
    for (int i = NUM_VEC - 1; i >= 0; i--) begin
      if (live[i]) begin
        found = 1'b1;
        pick  = SEL_W'(i);
      end
    end
  end

  always_comb begin
    clr = '0;
    if (hs) clr[cur_vec] = 1'b1;
  end

  always_comb begin
    case (reg_addr)
      3'd0:    reg_rdata = {COUNT, 15'd0, en_q};
      3'd1:    reg_rdata = {{(32-SEL_W){1'b0}}, sel_q};
      3'd2:    reg_rdata = lo_q[sel_q];
      3'd3:    reg_rdata = hi_q[sel_q];
      3'd4:    reg_rdata = dat_q[sel_q];
      3'd5:    reg_rdata = {31'd0, mask_q[sel_q]};
      default: reg_rdata = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_q   <= 1'b0;
      sel_q  <= '0;
      mask_q <= '1;
      for (int i = 0; i < NUM_VEC; i++) begin
        lo_q[i]  <= '0;
        hi_q[i]  <= '0;
        dat_q[i] <= '0;
      end
    end else begin
      if (wr_en) en_q <= reg_wdata[0];
      if (wr_sel && reg_wdata[15:0] < COUNT) sel_q <= reg_wdata[SEL_W-1:0];
      if (wr_lo) lo_q[sel_q] <= reg_wdata;
      if (wr_hi) hi_q[sel_q] <= reg_wdata;
      if (wr_dat) dat_q[sel_q] <= reg_wdata;
      if (wr_mask) mask_q[sel_q] <= reg_wdata[0];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend_q    <= '0;
      msg_valid <= 1'b0;
      cur_vec   <= '0;
      msg_addr  <= '0;
      msg_data  <= '0;
    end else begin
      pend_q <= (pend_q & ~clr) | (irq_req & {NUM_VEC{en_q}});
      if (hs) begin
        msg_valid <= 1'b0;
      end else if (!msg_valid && en_q && found) begin
        msg_valid <= 1'b1;
        cur_vec   <= pick;
        msg_addr  <= {hi_q[pick], lo_q[pick]};
        msg_data  <= dat_q[pick];
      end
    end
  end
endmodule

// File: rtl/msi_vector_store_chk.sv
module msi_vector_store_chk #(
  parameter int NUM_VEC = 8,
  parameter int SEL_W = 3
) (
  input logic               clk,
  input logic               rst_n,
  input logic               reg_we,
  input logic [2:0]         reg_addr,
  input logic [31:0]        reg_wdata,
  input logic               msg_valid,
  input logic               msg_ready,
  input logic [63:0]        msg_addr,
  input logic [31:0]        msg_data,
  input logic               en_q,
  input logic [SEL_W-1:0]   sel_q,
  input logic [NUM_VEC-1:0] mask_q,
  input logic [SEL_W-1:0]   cur_vec
);
  logic [NUM_VEC-1:0] mask_d;
  always_ff @(posedge clk) mask_d <= mask_q;

  assert_sel_in_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
    int'(sel_q) < NUM_VEC);

  assert_bad_sel_kept_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we && reg_addr == 3'd1 && int'(reg_wdata[15:0]) >= NUM_VEC) |=> $stable(sel_q));

  assert_msg_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (msg_valid && !msg_ready) |=> (msg_valid && $stable(msg_addr) && $stable(msg_data)));

  assert_launch_enabled_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(msg_valid) |-> $past(en_q));

  assert_launch_unmasked_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(msg_valid) |-> !mask_d[cur_vec]);
endmodule

bind msi_vector_store msi_vector_store_chk #(.NUM_VEC(NUM_VEC), .SEL_W(SEL_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
  .msg_valid(msg_valid), .msg_ready(msg_ready), .msg_addr(msg_addr), .msg_data(msg_data),
  .en_q(en_q), .sel_q(sel_q), .mask_q(mask_q), .cur_vec(cur_vec)
);

// File: tb/msi_vector_store_tb_top.sv
module msi_vector_store_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 8;

  logic          clk = 0;
  logic          rst_n = 0;
  logic          reg_we = 0;
  logic [2:0]    reg_addr = 0;
  logic [31:0]   reg_wdata = 0;
  logic [31:0]   reg_rdata;
  logic [NV-1:0] irq_req = 0;
  logic [NV-1:0] fb_irq;
  logic          msg_valid;
  logic          msg_ready = 1;
  logic [63:0]   msg_addr;
  logic [31:0]   msg_data;

  msi_vector_store #(.NUM_VEC(NV)) dut_i (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .irq_req(irq_req), .fb_irq(fb_irq), .msg_valid(msg_valid),
    .msg_ready(msg_ready), .msg_addr(msg_addr), .msg_data(msg_data)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 0;

  int        n_msg = 0;
  logic [63:0] log_addr [16];
  logic [31:0] log_data [16];

  always @(negedge clk) begin
    if (rst_n && msg_valid && msg_ready) begin
      if (n_msg < 16) begin
        log_addr[n_msg] = msg_addr;
        log_data[n_msg] = msg_data;
      end
      n_msg++;
    end
  end

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(logic [2:0] a, logic [31:0] d);
    @(negedge clk);
    reg_we = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 0;
  endtask

  task automatic rd(logic [2:0] a, output logic [31:0] d);
    reg_addr = a;
    #1;
    d = reg_rdata;
  endtask

  task automatic pulse(logic [NV-1:0] v);
    @(negedge clk);
    irq_req = v;
    @(negedge clk);
    irq_req = '0;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  // {we, addr, wdata, expected readback}
  localparam int NT = 17;
  localparam logic [67:0] TBL [NT] = '{
    {1'b0, 3'd0, 32'h0000_0000, 32'h0008_0000},
    {1'b1, 3'd0, 32'hFFFF_FFFF, 32'h0008_0001},
    {1'b1, 3'd0, 32'h0000_0000, 32'h0008_0000},
    {1'b0, 3'd5, 32'h0000_0000, 32'h0000_0001},
    {1'b1, 3'd1, 32'h0000_0003, 32'h0000_0003},
    {1'b1, 3'd1, 32'h0000_0008, 32'h0000_0003},
    {1'b1, 3'd1, 32'h0000_FFFF, 32'h0000_0003},
    {1'b1, 3'd2, 32'h1000_0030, 32'h1000_0030},
    {1'b1, 3'd3, 32'hDEAD_0001, 32'hDEAD_0001},
    {1'b1, 3'd4, 32'h0000_0303, 32'h0000_0303},
    {1'b1, 3'd5, 32'hFFFF_FFFE, 32'h0000_0000},
    {1'b1, 3'd1, 32'h0000_0007, 32'h0000_0007},
    {1'b0, 3'd2, 32'h0000_0000, 32'h0000_0000},
    {1'b0, 3'd5, 32'h0000_0000, 32'h0000_0001},
    {1'b1, 3'd6, 32'h0000_FFFF, 32'h0000_0000},
    {1'b1, 3'd1, 32'h0000_0003, 32'h0000_0003},
    {1'b0, 3'd4, 32'h0000_0000, 32'h0000_0303}
  };

  initial begin
    logic [31:0] r;
    idle(3);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    chk("R1 msg_valid", 64'(msg_valid), 64'd0);
    rd(3'd1, r); chk("R1 select", 64'(r), 64'd0);

    // Register table (R1 R2 R3 R4)
    for (int i = 0; i < NT; i++) begin
      if (TBL[i][67]) wr(TBL[i][66:64], TBL[i][63:32]);
      rd(TBL[i][66:64], r);
      chk($sformatf("R2/R3/R4 table step %0d", i), 64'(r), 64'(TBL[i][31:0]));
    end

    // Program all entries, masked (entry 3 stays unmasked from table; remask)
    for (int v = 0; v < NV; v++) begin
      wr(3'd1, 32'(v));
      wr(3'd2, 32'h4000_0000 + 32'(v) * 4);
      wr(3'd3, 32'h0000_00A0);
      wr(3'd4, 32'h100 + 32'(v));
      wr(3'd5, 32'd1);
    end

    // R5 fallback when disabled
    @(negedge clk);
    irq_req = 8'h10;
    #1;
    chk("R5 fb_irq passes request", 64'(fb_irq), 64'h10);
    @(negedge clk);
    irq_req = 0;
    wr(3'd1, 32'd4); wr(3'd5, 32'd0);
    idle(6);
    chk("R5 no message while disabled", 64'(n_msg), 64'd0);

    wr(3'd0, 32'd1);
    idle(4);
    chk("R5 disabled request not retained", 64'(n_msg), 64'd0);

    // R9 unmasked request issues one message
    wr(3'd1, 32'd2); wr(3'd5, 32'd0);
    @(negedge clk);
    irq_req = 8'h04;
    #1;
    chk("R9 fb_irq quiet when enabled", 64'(fb_irq), 64'd0);
    @(negedge clk);
    irq_req = 0;
    idle(6);
    chk("R9 one message", 64'(n_msg), 64'd1);
    chk("R9 address", log_addr[0], {32'hA0, 32'h4000_0008});
    chk("R9 payload", 64'(log_data[0]), 64'h102);

    // R6 masked request stays pending until unmasked
    pulse(8'h20);
    idle(6);
    chk("R6 masked gives no message", 64'(n_msg), 64'd1);
    wr(3'd1, 32'd5); wr(3'd5, 32'd0);
    idle(6);
    chk("R6 message after unmask", 64'(n_msg), 64'd2);
    chk("R6 payload", 64'(log_data[1]), 64'h105);
    chk("R6 address", log_addr[1], {32'hA0, 32'h4000_0014});

    // R7 / R8 ordering under backpressure
    wr(3'd1, 32'd1); wr(3'd5, 32'd0);
    wr(3'd1, 32'd3); wr(3'd5, 32'd0);
    wr(3'd1, 32'd6); wr(3'd5, 32'd0);
    msg_ready = 0;
    pulse(8'h4A);
    idle(2);
    chk("R8 valid under backpressure", 64'(msg_valid), 64'd1);
    chk("R7 lowest first", 64'(msg_data), 64'h101);
    wr(3'd1, 32'd1); wr(3'd4, 32'hBAD0_BAD0);
    idle(3);
    chk("R8 payload held after rewrite", 64'(msg_data), 64'h101);
    chk("R8 address held", msg_addr, {32'hA0, 32'h4000_0004});
    chk("R8 nothing accepted yet", 64'(n_msg), 64'd2);
    msg_ready = 1;
    idle(10);
    chk("R8 exactly three messages", 64'(n_msg), 64'd5);
    chk("R7 order first", 64'(log_data[2]), 64'h101);
    chk("R7 order second", 64'(log_data[3]), 64'h103);
    chk("R7 order third", 64'(log_data[4]), 64'h106);

    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule